// File: doc/BRIEF.md
# Ring Capture Writer

This block takes a continuous stream of 64-bit words, each holding four packed 16-bit samples, and stores them in a circular region of external memory through an AXI4 write master. Incoming words wait in an internal FIFO. When a full burst's worth has collected, the writer issues one 16-beat INCR burst. Its address is a runtime base plus an internal word offset scaled to bytes.

The word offset is a free-running counter of `OFFS_W` bits. It steps by the burst length each time a burst address is accepted and wraps to zero at its limit, so the memory region is reused as a ring. The counter is published live on a status output. Software polls it to see how far capture has run and copies out blocks that are complete. When the FIFO is full the stream is stalled, so no sample is ever dropped.

Top module: `ring_capture_writer`

## Requirements
- R1: `s_axis_tready` is high whenever the FIFO has a free slot and low when it holds `2**FIFO_LOG2` words; words offered while it is low are held by the source and are later written, none is lost.
- R2: A burst is launched only when the FIFO holds at least 16 words; every burst carries `awlen` = 15, `awsize` = 3 (8 bytes) and `awburst` = 2'b01 (INCR).
- R3: `m_axi_awaddr` equals `cfg_base` plus eight times the word offset, modulo 2**32; the base is taken at the moment a burst is launched.
- R4: The word offset steps by 16 on every accepted write address, wraps to zero after `2**OFFS_W` words, and is visible on `sts_offset` in the cycle after the step.
- R5: Data beats carry the stream words in arrival order with `wstrb` all ones; `wlast` is high on the 16th beat of a burst and on no other beat.
- R6: Only one burst is in flight: after an address is accepted, `awvalid` stays low until the write response of that burst has been taken.
- R7: `bready` is high, and the value of `bresp` is ignored: an error response (2'b10) changes neither the offset nor the bursts that follow.
- R8: A synchronous active-low reset empties the FIFO, clears the offset to zero and drops `awvalid` and `wvalid`; words buffered before the reset are never written.
- R9: Once raised, `awvalid` stays high with a stable `awaddr` until `awready`, and `wvalid` stays high with stable `wdata` until `wready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_base | input | ADDR_W | Byte base address of the ring region |
| sts_offset | output | OFFS_W | Current word offset into the ring |
| s_axis_tdata | input | DATA_W | Stream word of four packed samples |
| s_axis_tvalid | input | 1 | Stream word valid |
| s_axis_tready | output | 1 | Stream word accepted |
| m_axi_awaddr | output | ADDR_W | Burst start byte address |
| m_axi_awlen | output | 8 | Beats per burst minus one |
| m_axi_awsize | output | 3 | Log2 of bytes per beat |
| m_axi_awburst | output | 2 | Burst type (INCR) |
| m_axi_awvalid | output | 1 | Address valid |
| m_axi_awready | input | 1 | Address accepted |
| m_axi_wdata | output | DATA_W | Write data beat |
| m_axi_wstrb | output | DATA_W/8 | Byte enables |
| m_axi_wlast | output | 1 | Final beat of burst |
| m_axi_wvalid | output | 1 | Data valid |
| m_axi_wready | input | 1 | Data accepted |
| m_axi_bresp | input | 2 | Write response code |
| m_axi_bvalid | input | 1 | Response valid |
| m_axi_bready | output | 1 | Response accepted |

## Verification
The embedded assertions watch the per-cycle rules on every cycle:
- the hold of address and data while the slave stalls;
- a launch never occurring with fewer than a burst's worth of words buffered;
- the 16-word offset step after each address handshake;
- the absence of a new address right after a last beat;
- the FIFO never being read while empty.

Only the bench's scenarios show the end-to-end properties:
- word order and integrity across bursts;
- the exact addresses, including the ring wrap and base changes;
- stalling at a full FIFO without loss;
- indifference to error responses;
- the loss of buffered words across a reset.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_RESP = 2'd3
    } wr_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/rcw_fifo.sv
module rcw_fifo #(
    parameter int WIDTH      = 64,
    parameter int DEPTH_LOG2 = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WIDTH-1:0]      wr_data,
    output logic                  full,
    input  logic                  rd_en,
    output logic [WIDTH-1:0]      rd_data,
    output logic                  empty,
    output logic [DEPTH_LOG2:0]   level
);
    localparam int DEPTH = 2 ** DEPTH_LOG2;

    typedef struct packed {
        logic [DEPTH_LOG2:0] wr_ptr;
        logic [DEPTH_LOG2:0] rd_ptr;
    } fifo_regs_t;

    fifo_regs_t r_q, r_d;
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        r_d = r_q;
        if (wr_en) r_d.wr_ptr = r_q.wr_ptr + 1'b1;
        if (rd_en) r_d.rd_ptr = r_q.rd_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[r_q.wr_ptr[DEPTH_LOG2-1:0]] <= wr_data;
    end

    assign level   = r_q.wr_ptr - r_q.rd_ptr;
    assign empty   = (level == '0);
    assign full    = (level == (DEPTH_LOG2+1)'(DEPTH));
    assign rd_data = mem_q[r_q.rd_ptr[DEPTH_LOG2-1:0]];

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/rcw_burst_ctrl.sv
module rcw_burst_ctrl
    import rcw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int OFFS_W    = 20,
    parameter int BURST_LEN = 16,
    parameter int LVL_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_base,
    output logic [OFFS_W-1:0]    sts_offset,
    input  logic [LVL_W-1:0]     fifo_level,
    input  logic [DATA_W-1:0]    fifo_rd_data,
    output logic                 fifo_rd_en,
    output logic [ADDR_W-1:0]    awaddr,
    output logic [7:0]           awlen,
    output logic [2:0]           awsize,
    output logic [1:0]           awburst,
    output logic                 awvalid,
    input  logic                 awready,
    output logic [DATA_W-1:0]    wdata,
    output logic [DATA_W/8-1:0]  wstrb,
    output logic                 wlast,
    output logic                 wvalid,
    input  logic                 wready,
    input  logic                 bvalid,
    output logic                 bready
);
    localparam int BEAT_W  = $clog2(BURST_LEN);
    localparam int BYTE_SH = $clog2(DATA_W / 8);
    localparam int BOFF_W  = OFFS_W + BYTE_SH;

    typedef struct packed {
        wr_state_e           st;
        logic [OFFS_W-1:0]   offs;
        logic [ADDR_W-1:0]   addr;
        logic [BEAT_W-1:0]   beat;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;
    logic [BOFF_W-1:0] byte_off;
    logic              last_beat;

    assign byte_off  = {r_q.offs, {BYTE_SH{1'b0}}};
    assign last_beat = (r_q.beat == BEAT_W'(BURST_LEN - 1));

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (fifo_level >= LVL_W'(BURST_LEN)) begin
                    r_d.addr = cfg_base + ADDR_W'(byte_off);
                    r_d.st   = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (awready) begin
                    r_d.offs = r_q.offs + OFFS_W'(BURST_LEN);
                    r_d.beat = '0;
                    r_d.st   = ST_DATA;
                end
            end
            ST_DATA: begin
                if (wready) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (last_beat) r_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (bvalid) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.offs <= '0;
            r_q.addr <= '0;
            r_q.beat <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sts_offset = r_q.offs;
    assign awaddr     = r_q.addr;
    assign awlen      = 8'(BURST_LEN - 1);
    assign awsize     = 3'(BYTE_SH);
    assign awburst    = BURST_INCR;
    assign awvalid    = (r_q.st == ST_ADDR);
    assign wvalid     = (r_q.st == ST_DATA);
    assign wdata      = fifo_rd_data;
    assign wstrb      = '1;
    assign wlast      = wvalid && last_beat;
    assign fifo_rd_en = wvalid && wready;
    assign bready     = 1'b1;

    // R2
    aw_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (fifo_level >= LVL_W'(BURST_LEN)));
    // R9
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr)));
    // R9
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata)));
    // R4
    offs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready) |=> (sts_offset == $past(sts_offset) + OFFS_W'(BURST_LEN)));
    // R6
    one_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && wready && wlast) |=> !awvalid);
endmodule

// File: rtl/ring_capture_writer.sv
module ring_capture_writer #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int OFFS_W    = 20,
    parameter int BURST_LEN = 16,
    parameter int FIFO_LOG2 = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_base,
    output logic [OFFS_W-1:0]    sts_offset,
    input  logic [DATA_W-1:0]    s_axis_tdata,
    input  logic                 s_axis_tvalid,
    output logic                 s_axis_tready,
    output logic [ADDR_W-1:0]    m_axi_awaddr,
    output logic [7:0]           m_axi_awlen,
    output logic [2:0]           m_axi_awsize,
    output logic [1:0]           m_axi_awburst,
    output logic                 m_axi_awvalid,
    input  logic                 m_axi_awready,
    output logic [DATA_W-1:0]    m_axi_wdata,
    output logic [DATA_W/8-1:0]  m_axi_wstrb,
    output logic                 m_axi_wlast,
    output logic                 m_axi_wvalid,
    input  logic                 m_axi_wready,
    input  logic [1:0]           m_axi_bresp,
    input  logic                 m_axi_bvalid,
    output logic                 m_axi_bready
);
    localparam int LVL_W = FIFO_LOG2 + 1;

    logic              fifo_full, fifo_empty, fifo_rd_en, fifo_wr_en;
    logic [LVL_W-1:0]  fifo_level;
    logic [DATA_W-1:0] fifo_rd_data;
    logic [1:0]        unused_bresp;

    assign unused_bresp  = m_axi_bresp;
    assign s_axis_tready = !fifo_full;
    assign fifo_wr_en    = s_axis_tvalid && !fifo_full;

    rcw_fifo #(
        .WIDTH      (DATA_W),
        .DEPTH_LOG2 (FIFO_LOG2)
    ) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr_en),
        .wr_data (s_axis_tdata),
        .full    (fifo_full),
        .rd_en   (fifo_rd_en),
        .rd_data (fifo_rd_data),
        .empty   (fifo_empty),
        .level   (fifo_level)
    );

    rcw_burst_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .OFFS_W    (OFFS_W),
        .BURST_LEN (BURST_LEN),
        .LVL_W     (LVL_W)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_base     (cfg_base),
        .sts_offset   (sts_offset),
        .fifo_level   (fifo_level),
        .fifo_rd_data (fifo_rd_data),
        .fifo_rd_en   (fifo_rd_en),
        .awaddr       (m_axi_awaddr),
        .awlen        (m_axi_awlen),
        .awsize       (m_axi_awsize),
        .awburst      (m_axi_awburst),
        .awvalid      (m_axi_awvalid),
        .awready      (m_axi_awready),
        .wdata        (m_axi_wdata),
        .wstrb        (m_axi_wstrb),
        .wlast        (m_axi_wlast),
        .wvalid       (m_axi_wvalid),
        .wready       (m_axi_wready),
        .bvalid       (m_axi_bvalid),
        .bready       (m_axi_bready)
    );

    // R1
    tready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_axis_tvalid && !s_axis_tready) |-> !fifo_empty);
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!m_axi_awvalid && !m_axi_wvalid && sts_offset == '0 && s_axis_tready));
endmodule

// File: tb/test_ring_capture_writer.sv
module test_ring_capture_writer;
    localparam int OFFS_W = 8;
    localparam int RING   = 2 ** OFFS_W;
    localparam int NSC    = 4;
    localparam int SC_WORDS [NSC] = '{16, 48, 32, 64};
    localparam logic [31:0] SC_BASE [NSC] = '{32'h1000_0000, 32'h2000_0800, 32'hFFFF_FC00, 32'h0004_0000};
    localparam int SC_MODE [NSC] = '{0, 1, 0, 1};
    localparam int SC_ERR  [NSC] = '{0, 0, 1, 1};

    logic clk = 0, rst_n = 0;
    logic [31:0] cfg_base = 32'h1000_0000;
    logic [OFFS_W-1:0] sts_offset;
    logic [63:0] tdata = '0;
    logic tvalid = 0, tready;
    logic [31:0] awaddr; logic [7:0] awlen; logic [2:0] awsize; logic [1:0] awburst;
    logic awvalid, awready = 0;
    logic [63:0] wdata; logic [7:0] wstrb; logic wlast, wvalid, wready = 0;
    logic [1:0] bresp = 0; logic bvalid = 0, bready;

    always #4 clk = ~clk;

    ring_capture_writer #(.OFFS_W(OFFS_W)) i_ring_capture_writer (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .sts_offset(sts_offset),
        .s_axis_tdata(tdata), .s_axis_tvalid(tvalid), .s_axis_tready(tready),
        .m_axi_awaddr(awaddr), .m_axi_awlen(awlen), .m_axi_awsize(awsize),
        .m_axi_awburst(awburst), .m_axi_awvalid(awvalid), .m_axi_awready(awready),
        .m_axi_wdata(wdata), .m_axi_wstrb(wstrb), .m_axi_wlast(wlast),
        .m_axi_wvalid(wvalid), .m_axi_wready(wready), .m_axi_bresp(bresp),
        .m_axi_bvalid(bvalid), .m_axi_bready(bready)
    );

    int n_chk = 0, n_fail = 0;
    int sent_cnt = 0, rx_idx = 0, aw_cnt = 0, beat = 0, overlap = 0, cyc = 0;
    logic [63:0] sent [1024];
    bit in_flight = 0, resp_pend = 0, b_done = 0, aw_block = 0;
    int mode = 0, err_mode = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mkword(input int idx);
        return {32'hC0DE_0000 ^ 32'(idx), 32'(idx)};
    endfunction

    // slave model: observe at negedge, drive just after posedge
    initial begin
        forever begin
            @(negedge clk);
            b_done = 0;
            if (rst_n) begin
                if (awvalid && in_flight) overlap++;
                if (awvalid && awready) begin
                    logic [31:0] exp_a;
                    exp_a = cfg_base + 32'(((aw_cnt * 16) % RING) * 8);
                    chk(awaddr == exp_a, "R3 awaddr", awaddr, exp_a);
                    chk(awlen == 8'd15 && awsize == 3'd3 && awburst == 2'b01, "R2 aw fields",
                        {awlen, awsize, awburst}, {8'd15, 3'd3, 2'b01});
                    aw_cnt++; in_flight = 1; beat = 0;
                end
                if (wvalid && wready) begin
                    chk(wdata == sent[rx_idx % 1024], "R5 data order", wdata, sent[rx_idx % 1024]);
                    chk(wstrb == 8'hFF, "R5 wstrb", wstrb, 8'hFF);
                    beat++;
                    chk(wlast == (beat == 16), "R5 wlast", wlast, (beat == 16));
                    rx_idx++;
                    if (wlast) resp_pend = 1;
                end
                if (bvalid && bready) begin b_done = 1; in_flight = 0; end
            end
            @(posedge clk); #1;
            cyc++;
            if (!rst_n) begin
                bvalid = 0; resp_pend = 0; awready = 0; wready = 0;
            end else begin
                awready = !aw_block && (mode == 0 || (cyc % 3) != 0);
                wready  = (mode == 0 || (cyc % 4) != 1);
                if (b_done) bvalid = 0;
                else if (resp_pend) begin
                    bvalid = 1; resp_pend = 0;
                    bresp = err_mode ? 2'b10 : 2'b00;
                end
            end
        end
    end

    // call at posedge+1
    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            tvalid = 1; tdata = mkword(sent_cnt);
            do @(negedge clk); while (!tready);
            sent[sent_cnt % 1024] = tdata; sent_cnt++;
            @(posedge clk); #1;
        end
        tvalid = 0;
    endtask

    task automatic drain();
        while (rx_idx != sent_cnt || in_flight || bvalid || resp_pend) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int total;
        repeat (3) @(posedge clk); #1;
        @(negedge clk);
        chk(!awvalid && !wvalid && sts_offset == 0 && bready, "R8 reset state",
            {awvalid, wvalid, sts_offset}, 0);
        @(posedge clk); #1; rst_n = 1;
        @(posedge clk); #1;
        @(negedge clk);
        chk(tready == 1, "R1 tready idle", tready, 1);
        @(posedge clk); #1;

        // R2: fewer than 16 words never launch
        push_words(15);
        repeat (40) @(posedge clk); #1;
        chk(aw_cnt == 0 && !awvalid, "R2 no launch below 16", aw_cnt, 0);
        push_words(1);
        drain();
        chk(aw_cnt == 1, "R2 launch at 16", aw_cnt, 1);
        chk(sts_offset == 16, "R4 status step", sts_offset, 16);

        // table-driven scenarios
        total = 16;
        for (int s = 0; s < NSC; s++) begin
            cfg_base = SC_BASE[s]; mode = SC_MODE[s]; err_mode = SC_ERR[s];
            push_words(SC_WORDS[s]);
            drain();
            total += SC_WORDS[s];
            chk(aw_cnt == total / 16, "R4 burst count", aw_cnt, total / 16);
            chk(sts_offset == OFFS_W'(total % RING), "R7 R4 status after scenario",
                sts_offset, total % RING);
        end

        // R4 wrap: reach exactly RING words
        mode = 0; err_mode = 0; cfg_base = 32'h3000_0000;
        push_words(RING - total);
        drain();
        chk(sts_offset == 0, "R4 wrap to zero", sts_offset, 0);
        push_words(16);
        drain();
        chk(sts_offset == 16, "R4 after wrap", sts_offset, 16);

        // R1 backpressure: block address channel, fill FIFO
        aw_block = 1;
        push_words(32);
        tvalid = 1; tdata = mkword(sent_cnt);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tready == 0, "R1 tready low when full", tready, 0);
        chk(awvalid == 1, "R9 awvalid held", awvalid, 1);
        @(posedge clk); #1;
        aw_block = 0;
        do @(negedge clk); while (!tready);
        sent[sent_cnt % 1024] = tdata; sent_cnt++;
        @(posedge clk); #1; tvalid = 0;
        push_words(15);
        drain();
        chk(rx_idx == sent_cnt, "R1 no loss under backpressure", rx_idx, sent_cnt);

        // R8 reset mid-run with buffered words
        aw_block = 1;
        push_words(20);
        repeat (3) @(posedge clk); #1;
        rst_n = 0;
        repeat (2) @(posedge clk); #1;
        @(negedge clk);
        chk(!awvalid && !wvalid && sts_offset == 0 && tready, "R8 reset clears",
            {awvalid, wvalid, sts_offset, tready}, 1);
        @(posedge clk); #1;
        rx_idx = sent_cnt; aw_cnt = 0; in_flight = 0; aw_block = 0;
        rst_n = 1;
        repeat (30) @(posedge clk); #1;
        chk(aw_cnt == 0 && !awvalid, "R8 FIFO emptied", aw_cnt, 0);
        cfg_base = 32'h0000_0100;
        push_words(16);
        drain();
        chk(aw_cnt == 1 && sts_offset == 16, "R8 restart from offset zero", sts_offset, 16);

        chk(overlap == 0, "R6 single outstanding burst", overlap, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule